// File: doc/BRIEF.md
# Incremental Twiddle Scaling Unit

This block performs the twiddle-scaling step of a four-step number theoretic transform. It sits between the column-transform pass and the row-transform pass. A large transform of length N = ROWS x COLS is viewed as a matrix stored row after row. The block takes the matrix elements in that order and multiplies the element at row i, column j by w^(i*j) modulo a prime `MOD`. Here w is a root of unity of order N.

No table of powers is kept. Two running values are held instead. The first is a per-row step, w^i. The second is a scaling factor, which starts at 1 in column 0 and is multiplied by the step after every element. Each element therefore costs exactly two modular multiplications: one scales the data and one advances the factor. At the last column of a row, the factor multiplier computes the next row's step (step * w) instead, so no third multiplier is needed. Over a matrix the scaling costs about 2*N multiplications.

Both streams use valid/ready handshakes. An input word moves when `in_valid` and `in_ready` are both high on a clock edge. An output word moves when `out_valid` and `out_ready` are both high. The output is one register stage. The block accepts one element per cycle as long as that stage is empty or is being drained in the same cycle. While the output is stalled, the output word is held unchanged and `in_ready` stays low. `cfg_omega` is a plain configuration input. It must hold a value below `MOD`, and it must stay stable from the first element of a matrix until the last.

Top module: `twiddle_scaler`

## Requirements
- R1: Each accepted element d at row-major position (i,j) produces out_data = d * w^(i*j) mod MOD, where w is `cfg_omega` and d < MOD.
- R2: Positions advance one column per accepted element. After column COLS-1 the column returns to 0 and the row advances by one. After the last element of row ROWS-1, the position wraps to (0,0) without any marker.
- R3: An element accepted with `in_sof` high is treated as position (0,0) whatever the previous position was, including in the middle of a matrix.
- R4: Every element in row 0 or in column 0 leaves the block equal to its input value, because its factor is 1.
- R5: An element accepted on one clock edge is presented on `out_valid`/`out_data` right after that edge (one cycle of latency).
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_sof` hold their values and no input is taken.
- R7: `in_ready` is high exactly when the output stage is empty or `out_ready` is high, so one element per cycle flows under no back-pressure.
- R8: `out_sof` is high on, and only on, the output word of an element that was accepted with `in_sof` high.
- R9: After reset, `out_valid` is low, `in_ready` is high, and the position is (0,0) with a factor of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_omega | input | W | Root of unity w, below MOD, held stable for a whole matrix |
| in_valid | input | 1 | Input element valid |
| in_ready | output | 1 | Block can take an input element |
| in_data | input | W | Input element, below MOD |
| in_sof | input | 1 | Marks the first element of a matrix, position (0,0) |
| out_valid | output | 1 | Output element valid |
| out_ready | input | 1 | Downstream can take the output element |
| out_data | output | W | Scaled element |
| out_sof | output | 1 | Marks the scaled word of a start-of-matrix element |

## Verification
The first test streams a full matrix with no stalls and a fixed w. It shows whether the row-0 and column-0 identities hold. It also shows whether each row's step is built correctly from w at the row boundaries. Random valid and ready patterns, combined with a new random w for each matrix, separate a correct handshake from one that drops or repeats words under back-pressure. Both the scaled values and the held output words are checked. Directed cases cover a back-to-back second matrix sent without a marker, which exercises the wrap to (0,0). They also cover a marker inserted mid-row, which must restart the factor and step. A design that gets only the per-column update right fails these cases.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int unsigned DEF_W        = 32;
  localparam int unsigned DEF_MOD      = 998244353;
  localparam int unsigned DEF_ROW_BITS = 12;
  localparam int unsigned DEF_COL_BITS = 12;

  typedef struct packed {
    logic row_end;
    logic last_row;
  } tw_edge_t;
endpackage

// File: rtl/tw_mulmod.sv
module tw_mulmod #(
  parameter int unsigned W   = 32,
  parameter int unsigned MOD = 998244353
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  localparam int unsigned PW = 2 * W;
  localparam logic [PW-1:0] MOD_WIDE = PW'(MOD);

  logic [PW-1:0] prod;
  logic [PW-1:0] rem;

  always_comb begin
    prod = PW'(a) * PW'(b);
    rem  = prod % MOD_WIDE;
    y    = rem[W-1:0];
  end
endmodule

// File: rtl/tw_position.sv
module tw_position
  import tw_pkg::*;
#(
  parameter int unsigned ROW_BITS = 12,
  parameter int unsigned COL_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                advance,
  input  logic                restart,
  output logic [ROW_BITS-1:0] cur_row,
  output logic [COL_BITS-1:0] cur_col,
  output tw_edge_t            edge_o
);
  logic [ROW_BITS-1:0] row_q;
  logic [COL_BITS-1:0] col_q;

  always_comb begin
    cur_row         = restart ? '0 : row_q;
    cur_col         = restart ? '0 : col_q;
    edge_o.row_end  = &cur_col;
    edge_o.last_row = &cur_row;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (advance) begin
      if (edge_o.row_end) begin
        col_q <= '0;
        row_q <= cur_row + 1'b1;
      end else begin
        col_q <= cur_col + 1'b1;
        row_q <= cur_row;
      end
    end
  end

  // R2: a column advance keeps the row, the row end steps the row
  a_r2_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !edge_o.row_end |=> col_q == $past(cur_col) + 1'b1 && row_q == $past(cur_row));
  a_r2_row_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    advance && edge_o.row_end |=> col_q == '0);
  // R3: a restart puts the next position at column 1 of row 0
  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    advance && restart |=> row_q == '0 && col_q == COL_BITS'(1));
endmodule

// File: rtl/twiddle_scaler.sv
module twiddle_scaler
  import tw_pkg::*;
#(
  parameter int unsigned W        = DEF_W,
  parameter int unsigned MOD      = DEF_MOD,
  parameter int unsigned ROW_BITS = DEF_ROW_BITS,
  parameter int unsigned COL_BITS = DEF_COL_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cfg_omega,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         in_sof,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_sof
);
  localparam logic [W-1:0] ONE = W'(1);

  logic                accept;
  logic [ROW_BITS-1:0] cur_row;
  logic [COL_BITS-1:0] cur_col;
  tw_edge_t            edge_s;
  logic [W-1:0]        fac_q, step_q;
  logic [W-1:0]        fac_eff, step_eff;
  logic [W-1:0]        upd_a, upd_b, upd_y, scaled;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  tw_position #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_pos (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (accept),
    .restart (in_sof),
    .cur_row (cur_row),
    .cur_col (cur_col),
    .edge_o  (edge_s)
  );

  always_comb begin
    fac_eff  = in_sof ? ONE : fac_q;
    step_eff = in_sof ? ONE : step_q;
    // at a row end the factor is no longer needed: build the next step instead
    upd_a    = edge_s.row_end ? step_eff  : fac_eff;
    upd_b    = edge_s.row_end ? cfg_omega : step_eff;
  end

  tw_mulmod #(.W(W), .MOD(MOD)) u_mul_data (.a(in_data), .b(fac_eff), .y(scaled));
  tw_mulmod #(.W(W), .MOD(MOD)) u_mul_upd  (.a(upd_a),   .b(upd_b),   .y(upd_y));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fac_q  <= ONE;
      step_q <= ONE;
    end else if (accept) begin
      if (edge_s.row_end) begin
        fac_q  <= ONE;
        step_q <= edge_s.last_row ? ONE : upd_y;
      end else begin
        fac_q  <= upd_y;
        step_q <= step_eff;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= scaled;
      out_sof   <= in_sof;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R5: an accepted element is presented on the next cycle
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
  // R6: a stalled output word is held
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof));
  // R3: a start marker leaves the factor at 1 for the next column
  a_r3_sof_factor: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_sof |=> fac_q == ONE && step_q == ONE);
  // R4: the factor restarts at 1 after every row end
  a_r4_row_factor: assert property (@(posedge clk) disable iff (!rst_n)
    accept && edge_s.row_end |=> fac_q == ONE);
  // R1: the step stays fixed inside a row
  a_r1_step_stable: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !edge_s.row_end && !in_sof |=> $stable(step_q));
  // R9: register values just after reset
  a_r9_reset: assert property (@(posedge clk)
    !rst_n |=> !out_valid && fac_q == ONE && step_q == ONE);
endmodule

// File: tb/twiddle_scaler_tb.sv
module twiddle_scaler_tb;
  localparam int unsigned W = 9;
  localparam int unsigned MOD = 257;
  localparam int unsigned RB = 2;
  localparam int unsigned CB = 3;
  localparam int unsigned ROWS = 1 << RB;
  localparam int unsigned COLS = 1 << CB;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] cfg_omega = '0;
  logic in_valid = 1'b0, in_sof = 1'b0, out_ready = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid, out_sof;
  logic [W-1:0] out_data;

  int checks = 0, fails = 0;
  int unsigned exp_q[$];
  bit sof_q[$];
  int m_row = 0, m_col = 0;
  bit prev_acc = 0, prev_stall = 0;
  logic [W-1:0] stall_data;
  logic stall_sof;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twiddle_scaler #(.W(W), .MOD(MOD), .ROW_BITS(RB), .COL_BITS(CB)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_omega(cfg_omega),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof)
  );

  function automatic int unsigned pow_mod(int unsigned b, int unsigned e);
    longint unsigned r = 1;
    for (int unsigned k = 0; k < e; k++) r = (r * b) % MOD;
    return int'(r);
  endfunction

  task automatic check(bit ok, string req, int unsigned act, int unsigned expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // One cycle: drive at negedge, sample after settling, then wait for the edge.
  task automatic step(bit v, int unsigned d, bit s, bit rdy);
    bit acc_in, acc_out;
    @(negedge clk);
    in_valid = v; in_data = W'(d); in_sof = s; out_ready = rdy;
    #1;
    if (prev_acc) check(out_valid == 1'b1, "R5", out_valid, 1);
    if (prev_stall) begin
      check(out_valid && out_data == stall_data, "R6 data", out_data, stall_data);
      check(out_sof == stall_sof, "R6 sof", out_sof, stall_sof);
    end
    check(in_ready == (!out_valid || out_ready), "R7", in_ready, !out_valid || out_ready);
    acc_in  = in_valid && in_ready;
    acc_out = out_valid && out_ready;
    if (acc_out) begin
      if (exp_q.size() == 0) check(0, "R1 extra word", out_data, 0);
      else begin
        int unsigned e = exp_q.pop_front();
        bit es = sof_q.pop_front();
        check(out_data == W'(e), "R1 R2 R3 R4 value", out_data, e);
        check(out_sof == es, "R8", out_sof, es);
      end
    end
    if (acc_in) begin
      if (s) begin m_row = 0; m_col = 0; end
      exp_q.push_back(int'((longint'(d) * pow_mod(cfg_omega, m_row * m_col)) % MOD));
      sof_q.push_back(s);
      if (m_col == COLS - 1) begin m_col = 0; m_row = (m_row + 1) % ROWS; end
      else m_col++;
    end
    prev_acc = acc_in;
    prev_stall = out_valid && !out_ready;
    stall_data = out_data;
    stall_sof = out_sof;
  endtask

  task automatic drain();
    for (int k = 0; k < 4; k++) step(0, 0, 0, 1);
    check(exp_q.size() == 0, "R1 lost words", exp_q.size(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd1234);
    cfg_omega = 9'd136;
    repeat (3) @(negedge clk);
    // R9: reset values
    check(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R9 in_ready", in_ready, 1);
    rst_n = 1'b1;
    // R9: first element without marker is (0,0); R4 row 0 passes through
    step(1, 200, 0, 1);
    // R3: marker in mid-row restarts at (0,0)
    for (int k = 0; k < 3; k++) step(1, 10 + k, 0, 1);
    // R1 R2 R4: two full matrices, only the first with a marker (R2 wrap)
    for (int k = 0; k < 2 * ROWS * COLS; k++) step(1, (k * 37 + 5) % MOD, k == 0, 1);
    drain();
    // R3: marker in the middle of a row, then a full matrix
    for (int k = 0; k < 11; k++) step(1, 100 + k, 0, 1);
    for (int k = 0; k < ROWS * COLS + 3; k++) step(1, (k * 91 + 3) % MOD, k == 0, 1);
    drain();
    // random valid/ready with a new omega per matrix
    for (int m = 0; m < 6; m++) begin
      int sent = 0;
      drain();
      cfg_omega = W'(1 + $urandom % (MOD - 1));
      while (sent < ROWS * COLS) begin
        bit v = ($urandom % 4) != 0;
        bit r = ($urandom % 3) != 0;
        bit s = (sent == 0);
        step(v, $urandom % MOD, s && v, r);
        if (prev_acc) sent++;
      end
    end
    // R6: long stall with a full output stage
    step(1, 77, 1, 0);
    for (int k = 0; k < 5; k++) step(1, 78, 0, 0);
    drain();
    done = 1;
    summary();
  end
endmodule